// File: doc/BRIEF.md
# Data-Cache Maintenance Controller

This block is the maintenance front end of a small write-back data cache. Software drives it through a register port. A control register carries a disable bit and an invalidate-mode bit, and it shows a read-only flag that stays set while write-back is in progress. Four command registers start work on the cache. Two of them act on the single line that holds a given address, and the other two act on every line. One command of each pair invalidates, and the other writes back (flushes). When the mode bit is set, an invalidate command writes dirty lines back first and then drops them. This gives a combined flush-and-invalidate from the same command register.

The block walks its own tag, valid and dirty arrays. Each dirty line it has to clean leaves the block as one memory write beat per word, over a valid/ready port. A line becomes clean only when its last beat has been accepted. The load/store lookup path is not part of this block. A fill port and a probe port stand in for it: the fill port installs words and marks their line dirty, and the probe port reports whether an address hits and whether that line is dirty. Register writes that arrive while an operation is running are held off by keeping the port's ready low. Register reads are never held off.

Top module: `dcache_maint_ctrl`

## Requirements
- R1: After reset the control register reads 0, no memory write is offered, and every probe misses.
- R2: The control register has the disable bit at bit 0, the invalidate-mode bit at bit 6 and the write-back-in-progress flag at bit 8. Software can write bits 0 and 6. A write to bit 8 has no effect.
- R3: While the disable bit is 1, a write to any command register is accepted but changes no line and issues no memory write.
- R4: Whole-cache flush writes back every valid dirty line in ascending line order, with words in ascending address order. Each line stays valid and becomes clean, so a second flush right after issues no beats.
- R5: Whole-cache invalidate with mode 0 clears every line in exactly NUM_LINES cycles, at one line per clock. It issues no write and never raises the flag.
- R6: Whole-cache invalidate with mode 1 writes back every dirty line and then leaves every line invalid.
- R7: Single-line invalidate (select 1) acts only on the line whose index and tag match the written address. The byte-offset bits are ignored. With mode 0 the line is discarded. With mode 1 a dirty line is written back before it is dropped. A tag mismatch changes nothing.
- R8: Single-line flush (select 2) writes back only the addressed line, and only if it is dirty. The line stays valid and becomes clean.
- R9: The flag reads 1 from the cycle after a flush or write-back invalidate is accepted, until the operation ends. It reads 0 when no write-back operation is running.
- R10: While an operation runs, reg_ready is low for writes and high for reads.
- R11: A write beat holds its address and data until it is accepted. A line stays dirty until its last beat is taken.
- R12: A fill writes one word, marks the line valid and dirty, and takes the tag from the address. Register selects: 0 control, 1 line invalidate, 2 line flush, 3 whole invalidate, 4 whole flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Access taken; low for writes while busy |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | ADDR_W | Write data or command address |
| reg_rdata | output | ADDR_W | Control register read value (select 0) |
| mem_wvalid | output | 1 | Write-back beat offered |
| mem_wready | input | 1 | Write-back beat accepted |
| mem_waddr | output | ADDR_W | Byte address of the beat |
| mem_wdata | output | DATA_W | Word of the beat |
| fill_en | input | 1 | Install one word (ignored while busy) |
| fill_addr | input | ADDR_W | Address of the installed word |
| fill_data | input | DATA_W | Installed word |
| probe_addr | input | ADDR_W | Address to look up |
| probe_hit | output | 1 | Line valid with matching tag |
| probe_dirty | output | 1 | Hit line is dirty |

## Verification
The hardest state to reach from the ports is a write-back that is stalled partway through a line. In that state the flag must stay set, the probe must still see the line as dirty, and register writes must stay blocked while reads still go through. The bench gets there by holding the memory ready low for several cycles during a single-line flush. It checks all of these conditions mid-stall, then releases the ready and compares the beats against its model. The rest of the coverage comes from sweeping every line index under both mode values, with a matching tag, a mismatching tag and nonzero offset bits. Memory ready alternates cycle by cycle, so each beat is also held under back-pressure.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
    localparam logic [2:0] SEL_CTRL     = 3'd0;
    localparam logic [2:0] SEL_LINE_INV = 3'd1;
    localparam logic [2:0] SEL_LINE_FL  = 3'd2;
    localparam logic [2:0] SEL_ALL_INV  = 3'd3;
    localparam logic [2:0] SEL_ALL_FL   = 3'd4;

    localparam int BIT_DIS  = 0;
    localparam int BIT_MODE = 6;
    localparam int BIT_FLAG = 8;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_SCAN = 2'd1,
        W_BEAT = 2'd2
    } walk_st_e;

    typedef struct packed {
        logic all;
        logic inv;
        logic wb;
    } op_attr_t;
endpackage

// File: rtl/dcm_line_store.sv
module dcm_line_store #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              clr_en,
    input  logic [$clog2(NUM_LINES)-1:0] clr_idx,
    input  logic              clr_valid,
    input  logic              clr_dirty,
    input  logic [$clog2(NUM_LINES)-1:0] rd_idx,
    input  logic [$clog2(LINE_BYTES/(DATA_W/8))-1:0] rd_beat,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(NUM_LINES)-1:0] rd_tag,
    output logic [DATA_W-1:0] rd_word,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic              probe_dirty
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int WOFF       = $clog2(WORD_BYTES);
    localparam int BEAT_W     = $clog2(WORDS);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;

    typedef struct packed {
        logic [NUM_LINES-1:0]                   valid;
        logic [NUM_LINES-1:0]                   dirty;
        logic [NUM_LINES-1:0][TAG_W-1:0]        tag;
        logic [NUM_LINES*WORDS-1:0][DATA_W-1:0] data;
    } store_t;

    store_t q, d;

    logic [IDX_W-1:0]  fill_idx_d;
    logic [BEAT_W-1:0] fill_word_d;
    logic [TAG_W-1:0]  fill_tag_d;
    logic [IDX_W-1:0]  probe_idx_d;
    logic [TAG_W-1:0]  probe_tag_d;
    logic              unused_low_bits;

    assign fill_idx_d      = fill_addr[OFF_W +: IDX_W];
    assign fill_word_d     = fill_addr[WOFF +: BEAT_W];
    assign fill_tag_d      = fill_addr[ADDR_W-1 -: TAG_W];
    assign probe_idx_d     = probe_addr[OFF_W +: IDX_W];
    assign probe_tag_d     = probe_addr[ADDR_W-1 -: TAG_W];
    assign unused_low_bits = ^{fill_addr[WOFF-1:0], probe_addr[OFF_W-1:0]};

    always_comb begin
        d = q;
        if (fill_en) begin
            d.valid[fill_idx_d]                = 1'b1;
            d.dirty[fill_idx_d]                = 1'b1;
            d.tag[fill_idx_d]                  = fill_tag_d;
            d.data[{fill_idx_d, fill_word_d}]  = fill_data;
        end
        if (clr_en) begin
            if (clr_valid) d.valid[clr_idx] = 1'b0;
            if (clr_dirty) d.dirty[clr_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_valid    = q.valid[rd_idx];
    assign rd_dirty    = q.dirty[rd_idx];
    assign rd_tag      = q.tag[rd_idx];
    assign rd_word     = q.data[{rd_idx, rd_beat}];
    assign probe_hit   = q.valid[probe_idx_d] && (q.tag[probe_idx_d] == probe_tag_d);
    assign probe_dirty = probe_hit && q.dirty[probe_idx_d];

    // R12: installs never coincide with maintenance updates
    assert_fill_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !clr_en);
endmodule

// File: rtl/dcm_walker.sv
module dcm_walker
    import dcm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_attr_t          start_attr,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [$clog2(NUM_LINES)-1:0] rd_idx,
    output logic [$clog2(LINE_BYTES/(DATA_W/8))-1:0] rd_beat,
    input  logic              rd_valid,
    input  logic              rd_dirty,
    input  logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(NUM_LINES)-1:0] rd_tag,
    input  logic [DATA_W-1:0] rd_word,
    output logic              clr_en,
    output logic              clr_valid,
    output logic              clr_dirty,
    output logic              mem_wvalid,
    input  logic              mem_wready,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              flag
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int WOFF       = $clog2(WORD_BYTES);
    localparam int BEAT_W     = $clog2(WORDS);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_LINES - 1);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(WORDS - 1);

    typedef struct packed {
        walk_st_e          st;
        logic [IDX_W-1:0]  idx;
        logic [BEAT_W-1:0] beat;
        logic [TAG_W-1:0]  tag;
        op_attr_t          attr;
        logic              flag;
    } walk_t;

    walk_t q, d;
    logic  hit_d;
    logic  step_d;
    logic  unused_offset;

    assign unused_offset = ^start_addr[OFF_W-1:0];

    always_comb begin
        d          = q;
        clr_en     = 1'b0;
        clr_valid  = 1'b0;
        clr_dirty  = 1'b0;
        mem_wvalid = 1'b0;
        step_d     = 1'b0;
        hit_d      = rd_valid && (q.attr.all || (rd_tag == q.tag));
        case (q.st)
            W_IDLE: begin
                if (start) begin
                    d.st   = W_SCAN;
                    d.idx  = start_attr.all ? '0 : start_addr[OFF_W +: IDX_W];
                    d.tag  = start_addr[ADDR_W-1 -: TAG_W];
                    d.attr = start_attr;
                    d.flag = start_attr.wb;
                    d.beat = '0;
                end
            end
            W_SCAN: begin
                if (hit_d && q.attr.wb && rd_dirty) begin
                    d.st   = W_BEAT;
                    d.beat = '0;
                end else begin
                    clr_en    = hit_d && q.attr.inv;
                    clr_valid = 1'b1;
                    clr_dirty = 1'b1;
                    step_d    = 1'b1;
                end
            end
            W_BEAT: begin
                mem_wvalid = 1'b1;
                if (mem_wready) begin
                    if (q.beat == LAST_BEAT) begin
                        clr_en    = 1'b1;
                        clr_dirty = 1'b1;
                        clr_valid = q.attr.inv;
                        step_d    = 1'b1;
                    end else begin
                        d.beat = q.beat + 1'b1;
                    end
                end
            end
            default: d.st = W_IDLE;
        endcase
        if (step_d) begin
            if (q.attr.all && (q.idx != LAST_IDX)) begin
                d.idx = q.idx + 1'b1;
                d.st  = W_SCAN;
            end else begin
                d.st   = W_IDLE;
                d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: W_IDLE, default: '0};
        else        q <= d;
    end

    assign rd_idx    = q.idx;
    assign rd_beat   = q.beat;
    assign mem_waddr = {rd_tag, q.idx, q.beat, {WOFF{1'b0}}};
    assign mem_wdata = rd_word;
    assign busy      = (q.st != W_IDLE);
    assign flag      = q.flag;

    // R11: an offered beat is held unchanged until taken
    assert_beat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));
    // R9: write-back traffic only under the flag
    assert_beat_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> flag);
    // R9: flag never outlives the operation
    assert_flag_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> busy);
endmodule

// File: rtl/dcm_regif.sv
module dcm_regif
    import dcm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    output logic              reg_ready,
    input  logic              reg_write,
    input  logic [2:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              flag,
    output logic              start,
    output op_attr_t          start_attr,
    output logic [ADDR_W-1:0] start_addr
);
    typedef struct packed {
        logic dis;
        logic mode;
    } ctrl_t;

    ctrl_t q, d;
    logic  accept_d;

    always_comb begin
        d          = q;
        start      = 1'b0;
        start_attr = '0;
        reg_ready  = !reg_write || !busy;
        accept_d   = reg_valid && reg_write && !busy;
        if (accept_d) begin
            case (reg_sel)
                SEL_CTRL: begin
                    d.dis  = reg_wdata[BIT_DIS];
                    d.mode = reg_wdata[BIT_MODE];
                end
                SEL_LINE_INV: begin
                    start      = !q.dis;
                    start_attr = '{all: 1'b0, inv: 1'b1, wb: q.mode};
                end
                SEL_LINE_FL: begin
                    start      = !q.dis;
                    start_attr = '{all: 1'b0, inv: 1'b0, wb: 1'b1};
                end
                SEL_ALL_INV: begin
                    start      = !q.dis;
                    start_attr = '{all: 1'b1, inv: 1'b1, wb: q.mode};
                end
                SEL_ALL_FL: begin
                    start      = !q.dis;
                    start_attr = '{all: 1'b1, inv: 1'b0, wb: 1'b1};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start_addr = reg_wdata;

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_CTRL) begin
            reg_rdata[BIT_DIS]  = q.dis;
            reg_rdata[BIT_MODE] = q.mode;
            reg_rdata[BIT_FLAG] = flag;
        end
    end

    // R9: an accepted whole flush raises the flag next cycle
    assert_flush_raises_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_ready && (reg_sel == SEL_ALL_FL) && !q.dis) |=> flag);
    // R3: commands taken while disabled start nothing
    assert_disabled_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_ready && (reg_sel != SEL_CTRL) && q.dis) |=> !busy);
endmodule

// File: rtl/dcache_maint_ctrl.sv
module dcache_maint_ctrl
    import dcm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    output logic              reg_ready,
    input  logic              reg_write,
    input  logic [2:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              mem_wvalid,
    input  logic              mem_wready,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic              probe_dirty
);
    localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
    localparam int BEAT_W = $clog2(WORDS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

    logic              busy, flag, start;
    op_attr_t          start_attr;
    logic [ADDR_W-1:0] start_addr;
    logic [IDX_W-1:0]  rd_idx;
    logic [BEAT_W-1:0] rd_beat;
    logic              rd_valid, rd_dirty;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_word;
    logic              clr_en, clr_valid, clr_dirty;

    dcm_regif #(.ADDR_W(ADDR_W)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_valid  (reg_valid),
        .reg_ready  (reg_ready),
        .reg_write  (reg_write),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .flag       (flag),
        .start      (start),
        .start_attr (start_attr),
        .start_addr (start_addr)
    );

    dcm_walker #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_attr (start_attr),
        .start_addr (start_addr),
        .rd_idx     (rd_idx),
        .rd_beat    (rd_beat),
        .rd_valid   (rd_valid),
        .rd_dirty   (rd_dirty),
        .rd_tag     (rd_tag),
        .rd_word    (rd_word),
        .clr_en     (clr_en),
        .clr_valid  (clr_valid),
        .clr_dirty  (clr_dirty),
        .mem_wvalid (mem_wvalid),
        .mem_wready (mem_wready),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .flag       (flag)
    );

    dcm_line_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_en     (fill_en && !busy),
        .fill_addr   (fill_addr),
        .fill_data   (fill_data),
        .clr_en      (clr_en),
        .clr_idx     (rd_idx),
        .clr_valid   (clr_valid),
        .clr_dirty   (clr_dirty),
        .rd_idx      (rd_idx),
        .rd_beat     (rd_beat),
        .rd_valid    (rd_valid),
        .rd_dirty    (rd_dirty),
        .rd_tag      (rd_tag),
        .rd_word     (rd_word),
        .probe_addr  (probe_addr),
        .probe_hit   (probe_hit),
        .probe_dirty (probe_dirty)
    );
endmodule

// File: tb/sim_dcache_maint_ctrl.sv
`timescale 1ns/1ps
module sim_dcache_maint_ctrl;
    localparam int AW = 32, DW = 32, LB = 16, NL = 4, WPL = 4, OFF = 4, IW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_valid = 1'b0, reg_write = 1'b1;
    logic [2:0] reg_sel = 3'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic reg_ready;
    logic [AW-1:0] reg_rdata;
    logic mem_wvalid, mem_wready = 1'b1;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic fill_en = 1'b0;
    logic [AW-1:0] fill_addr = '0, probe_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic probe_hit, probe_dirty;

    always #10 clk = ~clk;

    dcache_maint_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINE_BYTES(LB), .NUM_LINES(NL)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
        .reg_write(reg_write), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
        .probe_addr(probe_addr), .probe_hit(probe_hit), .probe_dirty(probe_dirty));

    int n_chk = 0, n_fail = 0;
    int rdy_mode = 0;
    int cyc = 0;
    bit mv[NL], md[NL];
    int mt[NL];
    logic [31:0] mdat[NL][WPL];
    logic [31:0] ga[64], gd[64], ea[64], ed[64];
    int gn = 0, en = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input int tag, input int idx, input int w);
        return (32'(tag) << (OFF + IW)) | (32'(idx) << OFF) | (32'(w) << 2);
    endfunction

    always @(negedge clk) begin
        cyc++;
        case (rdy_mode)
            0: mem_wready = 1'b1;
            1: mem_wready = cyc[0];
            default: mem_wready = 1'b0;
        endcase
    end

    always @(negedge clk) begin
        #1;
        if (mem_wvalid && mem_wready && gn < 64) begin
            ga[gn] = mem_waddr; gd[gn] = mem_wdata; gn++;
        end
    end

    task automatic reg_wr(input logic [2:0] s, input logic [31:0] v);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_sel = s; reg_wdata = v;
        #1;
        while (!reg_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        reg_valid = 1'b0; reg_sel = 3'd0;
    endtask

    task automatic do_cmd(input logic [2:0] s, input logic [31:0] v, output int n,
                          output bit f_first, output bit f_any);
        reg_wr(s, v);
        @(negedge clk); #1;
        n = 0; f_first = reg_rdata[8]; f_any = 1'b0;
        while (!reg_ready) begin
            n++;
            if (reg_rdata[8]) f_any = 1'b1;
            @(negedge clk); #1;
        end
        chk(reg_rdata[8] == 1'b0, "R9", "flag after end", reg_rdata[8], 0);
    endtask

    task automatic fill_line(input int tag, input int idx, input int salt);
        for (int w = 0; w < WPL; w++) begin
            @(negedge clk);
            fill_en = 1'b1; fill_addr = mk_addr(tag, idx, w);
            fill_data = 32'((tag << 16) ^ (idx << 8) ^ w ^ (salt << 24));
            mdat[idx][w] = fill_data;
        end
        @(negedge clk); fill_en = 1'b0;
        mv[idx] = 1'b1; md[idx] = 1'b1; mt[idx] = tag;
    endtask

    task automatic check_lines(input string req);
        for (int i = 0; i < NL; i++) begin
            @(negedge clk);
            probe_addr = mk_addr(mt[i], i, 1);
            #1;
            chk(probe_hit == mv[i], req, "probe hit", probe_hit, mv[i]);
            chk(probe_dirty == (mv[i] && md[i]), req, "probe dirty", probe_dirty, mv[i] && md[i]);
        end
    endtask

    task automatic exp_line(input int i);
        for (int w = 0; w < WPL; w++) begin
            ea[en] = mk_addr(mt[i], i, w); ed[en] = mdat[i][w]; en++;
        end
    endtask

    task automatic model_op(input bit all, input bit inv, input bit wb, input int tag, input int idx);
        for (int i = 0; i < NL; i++) begin
            if ((all || (i == idx && mt[i] == tag)) && mv[i]) begin
                if (wb && md[i]) begin exp_line(i); md[i] = 1'b0; end
                if (inv) begin mv[i] = 1'b0; md[i] = 1'b0; end
            end
        end
    endtask

    task automatic cmp(input string req);
        chk(gn == en, req, "beat count", gn, en);
        for (int k = 0; k < en && k < gn; k++) begin
            chk(ga[k] == ea[k], req, "beat addr", ga[k], ea[k]);
            chk(gd[k] == ed[k], req, "beat data", gd[k], ed[k]);
        end
        gn = 0; en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n; bit ff, fa;
        for (int i = 0; i < NL; i++) begin mv[i] = 0; md[i] = 0; mt[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk(reg_rdata == 0, "R1", "ctrl after reset", reg_rdata, 0);
        chk(mem_wvalid == 0, "R1", "wvalid after reset", mem_wvalid, 0);
        check_lines("R1");

        // R2 register layout, flag bit not writable
        reg_wr(3'd0, 32'h141);
        @(negedge clk); #1;
        chk(reg_rdata == 32'h41, "R2", "ctrl readback", reg_rdata, 32'h41);
        reg_wr(3'd0, 32'h0);

        // R12 fills
        for (int i = 0; i < NL; i++) fill_line(16 + i, i, 1);
        check_lines("R12");

        // R4 whole flush with alternating ready
        rdy_mode = 1;
        model_op(1, 0, 1, 0, 0);
        do_cmd(3'd4, 0, n, ff, fa);
        chk(ff == 1, "R9", "flag after flush accept", ff, 1);
        cmp("R4");
        check_lines("R4");
        do_cmd(3'd4, 0, n, ff, fa);
        cmp("R4");

        // R7/R8 line sweep under both modes
        for (int mode = 0; mode < 2; mode++) begin
            reg_wr(3'd0, mode ? 32'h40 : 32'h0);
            for (int i = 0; i < NL; i++) begin
                for (int j = 0; j < NL; j++) fill_line(32 + j + mode, j, i + 2);
                do_cmd(3'd1, mk_addr(99, i, 0), n, ff, fa);
                cmp("R7");
                check_lines("R7");
                model_op(0, 1, mode[0], 32 + i + mode, i);
                do_cmd(3'd1, mk_addr(32 + i + mode, i, 3) | 32'h3, n, ff, fa);
                chk(ff == mode[0], "R9", "flag on line invalidate", ff, mode);
                cmp("R7");
                check_lines("R7");
                model_op(0, 0, 1, 32 + ((i + 1) % NL) + mode, (i + 1) % NL);
                do_cmd(3'd2, mk_addr(32 + ((i + 1) % NL) + mode, (i + 1) % NL, 2) | 32'h1, n, ff, fa);
                cmp("R8");
                check_lines("R8");
            end
        end
        reg_wr(3'd0, 32'h0);

        // R11/R10 stalled write-back
        fill_line(70, 1, 9);
        rdy_mode = 2;
        reg_wr(3'd2, mk_addr(70, 1, 0));
        repeat (6) @(negedge clk);
        #1;
        chk(reg_rdata[8] == 1, "R11", "flag mid-stall", reg_rdata[8], 1);
        chk(reg_ready == 0, "R10", "write ready while busy", reg_ready, 0);
        reg_write = 1'b0; #1;
        chk(reg_ready == 1, "R10", "read ready while busy", reg_ready, 1);
        reg_write = 1'b1;
        probe_addr = mk_addr(70, 1, 0); #1;
        chk(probe_dirty == 1, "R11", "dirty mid-stall", probe_dirty, 1);
        chk(gn == 0, "R11", "no beat taken", gn, 0);
        rdy_mode = 0;
        model_op(0, 0, 1, 70, 1);
        while (!reg_ready) begin @(negedge clk); #1; end
        cmp("R11");
        check_lines("R11");

        // R3 disabled commands
        for (int i = 0; i < NL; i++) fill_line(80 + i, i, 11);
        reg_wr(3'd0, 32'h41);
        do_cmd(3'd3, 0, n, ff, fa);
        chk(n == 0, "R3", "busy cycles", n, 0);
        do_cmd(3'd4, 0, n, ff, fa);
        do_cmd(3'd1, mk_addr(81, 1, 0), n, ff, fa);
        cmp("R3");
        check_lines("R3");

        // R5 discard all
        reg_wr(3'd0, 32'h0);
        do_cmd(3'd3, 0, n, ff, fa);
        model_op(1, 1, 0, 0, 0);
        chk(n == NL, "R5", "busy cycles", n, NL);
        chk(fa == 0, "R5", "flag seen", fa, 0);
        cmp("R5");
        check_lines("R5");

        // R6 write-back then invalidate all
        for (int i = 0; i < NL; i += 2) fill_line(90 + i, i, 12);
        reg_wr(3'd0, 32'h40);
        rdy_mode = 1;
        model_op(1, 1, 1, 0, 0);
        do_cmd(3'd3, 0, n, ff, fa);
        chk(ff == 1, "R6", "flag raised", ff, 1);
        cmp("R6");
        check_lines("R6");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule